// File: doc/BRIEF.md
# NAPOT-Aware Three-Level Page Table Walker

The walker resolves one translation miss at a time for a 39-bit virtual address space with three levels of page tables. A request hands it a virtual address and the page number of the root table. It then issues one 64-bit read per level on a simple request/response port and interprets each entry it gets back. The walk ends in one of two ways: a fill record for the translation buffer, or a page-fault indication that carries the level where the walk stopped.

Leaf entries may carry a contiguity marker. This marker declares the page to be part of a naturally aligned 64 KiB block. The walker accepts the marker only on a 4 KiB leaf whose low four page-number bits hold the single legal pattern, and it then sets a flag in the fill record. Any other use of the marker is a fault. A build parameter removes the feature, and the marker bit is then ignored.

Top module: `napot_walker`

## Requirements
- R1: After reset, and until the first request, `mem_req_o`, `fill_valid_o`, `fault_valid_o` and `walk_busy_o` are all low.
- R2: Each entry read is a one-cycle `mem_req_o` pulse at address `table_ppn*4096 + index*8`. The index is vaddr[38:30] at level 0, vaddr[29:21] at level 1 and vaddr[20:12] at level 2. The first read uses the root page number.
- R3: An entry in the 64-bit format has V at bit 0, R at bit 1, W at bit 2 and X at bit 3, the page number at bits 53:10, and the marker N at bit 63. If V=1, R=0 and X=0, the entry points to the next table, whose page number is the entry's page number. A pointer found at level 2 faults with level 2.
- R4: An entry with V=0, or with W=1 and R=0, faults at the level where it was read.
- R5: A leaf with N=0 produces a fill. The fill carries the entry's page number, its low 8 flag bits, the level and a cleared NAPOT flag.
- R6: A leaf at level 2 with N=1 and page number bits [3:0] = 4'b1000 produces a fill with the NAPOT flag set.
- R7: A leaf at level 2 with N=1 and any other value in page number bits [3:0] faults with level 2.
- R8: A leaf with N=1 at level 0 or level 1 faults at that level.
- R9: Every accepted walk ends in exactly one pulse, lasting one cycle, on either `fill_valid_o` or `fault_valid_o`. The pulse comes with the walk's virtual address and level.
- R10: With `NAPOT_EN=0`, N is ignored. Leaves that R6, R7 and R8 would handle fill normally, with the NAPOT flag cleared.
- R11: While `walk_busy_o` is high, `walk_req_i` is ignored: no further walk is started and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| walk_req_i | input | 1 | Start a walk (sampled only while idle) |
| walk_vaddr_i | input | 39 | Virtual address to translate |
| walk_root_ppn_i | input | 44 | Page number of the root table |
| walk_busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Entry read request, one-cycle pulse |
| mem_addr_o | output | 56 | Physical address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry returned by memory |
| fill_valid_o | output | 1 | Fill record valid, one-cycle pulse |
| fill_ppn_o | output | 44 | Leaf page number |
| fill_perm_o | output | 8 | Leaf flag bits 7:0 |
| fill_napot_o | output | 1 | Leaf is a 64 KiB NAPOT mapping |
| fault_valid_o | output | 1 | Page fault, one-cycle pulse |
| out_level_o | output | 2 | Level at which the walk ended |
| out_vaddr_o | output | 39 | Virtual address of the finished walk |

## Verification
The assertions check, on every cycle, the shape of each pulse on the read and result ports. They also check that a new walk's first read comes from the root table, that any fill carrying the NAPOT flag is a level-2 leaf with the legal low pattern, and that a build without NAPOT never sets the flag. Only the bench scenarios can show which entry patterns lead to a fault or a fill, and at which level. The same applies to the exact address sequence through the tables, the behaviour of the build without NAPOT on marked leaves, and the rejection of requests while busy.

// File: rtl/napot_walker_pkg.sv
package napot_walker_pkg;
  localparam int unsigned PPN_W = 44;
  localparam int unsigned PTE_W = 64;

  typedef struct packed {
    logic             n;
    logic [8:0]       rsvd;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       rsw;
    logic             d;
    logic             a;
    logic             g;
    logic             u;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;

  typedef enum logic [1:0] {
    DEC_FAULT = 2'd0,
    DEC_NEXT  = 2'd1,
    DEC_LEAF  = 2'd2
  } pte_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_RESP  = 3'd1,
    ST_LEAF_CHECK = 3'd2,
    ST_PROP_ERR   = 3'd3,
    ST_DONE       = 3'd4
  } walk_state_e;
endpackage

// File: rtl/napot_walker_addr.sv
module napot_walker_addr #(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned VPN_W  = 9,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned VA_W   = 12 + VPN_W*LEVELS,
  parameter int unsigned PA_W   = napot_walker_pkg::PPN_W + 12
) (
  input  logic [napot_walker_pkg::PPN_W-1:0] ppn_i,
  input  logic [VA_W-1:0]                    vaddr_i,
  input  logic [LVL_W-1:0]                   lvl_i,
  output logic [PA_W-1:0]                    addr_o
);
  localparam int unsigned NSEL = 1 << LVL_W;

  logic [VPN_W-1:0] vpn_sel [NSEL];
  logic [VPN_W-1:0] idx;
  logic             unused_vaddr;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    if (g < LEVELS) begin : g_lvl
      assign vpn_sel[g] = vaddr_i[12 + VPN_W*(LEVELS-1-g) +: VPN_W];
    end else begin : g_pad
      assign vpn_sel[g] = '0;
    end
  end

  assign unused_vaddr = ^vaddr_i[11:0];
  assign idx    = vpn_sel[lvl_i];
  assign addr_o = {ppn_i, 12'h000} + PA_W'({idx, 3'b000});
endmodule

// File: rtl/napot_walker_decode.sv
module napot_walker_decode #(
  parameter bit NAPOT_EN = 1'b1
) (
  input  napot_walker_pkg::pte_t      pte_i,
  input  logic                        is_last_i,
  output napot_walker_pkg::pte_kind_e kind_o,
  output logic                        napot_o
);
  import napot_walker_pkg::*;

  logic bad, ptr, marked, napot_ok;
  logic unused_bits;

  assign unused_bits = ^{pte_i.rsvd, pte_i.rsw, pte_i.d, pte_i.a, pte_i.g, pte_i.u,
                         pte_i.ppn[PPN_W-1:4]};
  assign bad      = !pte_i.v || (pte_i.w && !pte_i.r);
  assign ptr      = !pte_i.r && !pte_i.x;
  assign marked   = NAPOT_EN && pte_i.n;
  // only the 64 KiB pattern on a 4 KiB leaf is legal
  assign napot_ok = is_last_i && (pte_i.ppn[3:0] == 4'b1000);

  always_comb begin
    kind_o  = DEC_LEAF;
    napot_o = 1'b0;
    if (bad) begin
      kind_o = DEC_FAULT;
    end else if (ptr) begin
      kind_o = is_last_i ? DEC_FAULT : DEC_NEXT;
    end else if (marked) begin
      if (napot_ok) napot_o = 1'b1;
      else          kind_o  = DEC_FAULT;
    end
  end
endmodule

// File: rtl/napot_walker.sv
module napot_walker #(
  parameter int unsigned LEVELS   = 3,
  parameter int unsigned VPN_W    = 9,
  parameter bit          NAPOT_EN = 1'b1,
  parameter int unsigned LVL_W    = $clog2(LEVELS),
  parameter int unsigned VA_W     = 12 + VPN_W*LEVELS,
  parameter int unsigned PA_W     = napot_walker_pkg::PPN_W + 12
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                walk_req_i,
  input  logic [VA_W-1:0]                     walk_vaddr_i,
  input  logic [napot_walker_pkg::PPN_W-1:0]  walk_root_ppn_i,
  output logic                                walk_busy_o,
  output logic                                mem_req_o,
  output logic [PA_W-1:0]                     mem_addr_o,
  input  logic                                mem_rvalid_i,
  input  logic [napot_walker_pkg::PTE_W-1:0]  mem_rdata_i,
  output logic                                fill_valid_o,
  output logic [napot_walker_pkg::PPN_W-1:0]  fill_ppn_o,
  output logic [7:0]                          fill_perm_o,
  output logic                                fill_napot_o,
  output logic                                fault_valid_o,
  output logic [LVL_W-1:0]                    out_level_o,
  output logic [VA_W-1:0]                     out_vaddr_o
);
  import napot_walker_pkg::*;

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  vaddr_q;
  pte_t             pte_q;
  logic             req_q, napot_q;
  pte_kind_e        dec_kind;
  logic             dec_napot;

  napot_walker_addr #(
    .LEVELS(LEVELS), .VPN_W(VPN_W), .LVL_W(LVL_W), .VA_W(VA_W), .PA_W(PA_W)
  ) u_addr (
    .ppn_i  (ppn_q),
    .vaddr_i(vaddr_q),
    .lvl_i  (lvl_q),
    .addr_o (mem_addr_o)
  );

  napot_walker_decode #(.NAPOT_EN(NAPOT_EN)) u_dec (
    .pte_i    (pte_q),
    .is_last_i(lvl_q == LAST_LVL),
    .kind_o   (dec_kind),
    .napot_o  (dec_napot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      ppn_q   <= '0;
      vaddr_q <= '0;
      pte_q   <= '0;
      req_q   <= 1'b0;
      napot_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (walk_req_i) begin
          vaddr_q <= walk_vaddr_i;
          ppn_q   <= walk_root_ppn_i;
          lvl_q   <= '0;
          req_q   <= 1'b1;
          state_q <= ST_WAIT_RESP;
        end
        ST_WAIT_RESP: if (mem_rvalid_i) begin
          pte_q   <= pte_t'(mem_rdata_i);
          state_q <= ST_LEAF_CHECK;
        end
        ST_LEAF_CHECK: begin
          unique case (dec_kind)
            DEC_NEXT: begin
              ppn_q   <= pte_q.ppn;
              lvl_q   <= lvl_q + 1'b1;
              req_q   <= 1'b1;
              state_q <= ST_WAIT_RESP;
            end
            DEC_LEAF: begin
              napot_q <= dec_napot;
              state_q <= ST_DONE;
            end
            default: state_q <= ST_PROP_ERR;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_busy_o   = (state_q != ST_IDLE);
  assign mem_req_o     = req_q;
  assign fill_valid_o  = (state_q == ST_DONE);
  assign fault_valid_o = (state_q == ST_PROP_ERR);
  assign fill_ppn_o    = pte_q.ppn;
  assign fill_perm_o   = pte_q[7:0];
  assign fill_napot_o  = napot_q;
  assign out_level_o   = lvl_q;
  assign out_vaddr_o   = vaddr_q;

  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_root_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(walk_busy_o) |-> mem_req_o && (mem_addr_o[PA_W-1:12] == $past(walk_root_ppn_i)));
  assert_napot_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && fill_napot_o) |-> (out_level_o == LAST_LVL) && (fill_ppn_o[3:0] == 4'b1000));
  assert_fill_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o && !fault_valid_o);
  assert_fault_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |=> !fault_valid_o && !fill_valid_o);
  assert_no_napot_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (NAPOT_EN || !fill_napot_o));
  assert_no_req_in_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> walk_busy_o);
endmodule

// File: tb/napot_walker_test.sv
module napot_walker_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit      fault;
    int      lvl;
    longint  ppn;
    int      perm;
    bit      napot;
    longint  va;
    string   req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [longint];
  exp_t   exp_q[$], exp_q2[$];
  longint addr_q[$];
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // main instance
  logic        req, busy, mreq, rvalid, fv, fltv, fnapot;
  logic [38:0] va, ova;
  logic [43:0] root, fppn;
  logic [55:0] maddr;
  logic [63:0] rdata;
  logic [7:0]  fperm;
  logic [1:0]  olvl;
  // instance built without NAPOT
  logic        req2, busy2, mreq2, rvalid2, fv2, fltv2, fnapot2;
  logic [38:0] va2, ova2;
  logic [43:0] fppn2;
  logic [55:0] maddr2;
  logic [63:0] rdata2;
  logic [7:0]  fperm2;
  logic [1:0]  olvl2;

  napot_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .walk_req_i(req), .walk_vaddr_i(va),
    .walk_root_ppn_i(root), .walk_busy_o(busy), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .fill_valid_o(fv), .fill_ppn_o(fppn),
    .fill_perm_o(fperm), .fill_napot_o(fnapot), .fault_valid_o(fltv),
    .out_level_o(olvl), .out_vaddr_o(ova));

  napot_walker #(.NAPOT_EN(1'b0)) uut_nn (
    .clk_i(clk), .rst_ni(rst_n), .walk_req_i(req2), .walk_vaddr_i(va2),
    .walk_root_ppn_i(root), .walk_busy_o(busy2), .mem_req_o(mreq2), .mem_addr_o(maddr2),
    .mem_rvalid_i(rvalid2), .mem_rdata_i(rdata2), .fill_valid_o(fv2), .fill_ppn_o(fppn2),
    .fill_perm_o(fperm2), .fill_napot_o(fnapot2), .fault_valid_o(fltv2),
    .out_level_o(olvl2), .out_vaddr_o(ova2));

  function automatic logic [63:0] rd(input longint a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mk(input longint ppn, input int fl, input bit n);
    return {n, 9'h0, ppn[43:0], 2'b00, fl[7:0]};
  endfunction

  function automatic longint mkva(input int v2, input int v1, input int v0);
    return (longint'(v2) << 30) | (longint'(v1) << 21) | (longint'(v0) << 12) | 64'h123;
  endfunction

  // memory responders, two-cycle latency
  longint pa1, pa2;
  int cnt1 = 0, cnt2 = 0;
  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (cnt1 == 1) begin rvalid <= 1'b1; rdata <= rd(pa1); end
    if (cnt1 > 0) cnt1 <= cnt1 - 1;
    if (mreq) begin pa1 <= longint'(maddr); cnt1 <= 2; end
  end
  always @(posedge clk) begin
    rvalid2 <= 1'b0;
    if (cnt2 == 1) begin rvalid2 <= 1'b1; rdata2 <= rd(pa2); end
    if (cnt2 > 0) cnt2 <= cnt2 - 1;
    if (mreq2) begin pa2 <= longint'(maddr2); cnt2 <= 2; end
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic cmp(input exp_t e, input bit flt, input int l, input longint p,
                     input int pm, input bit nf, input longint a);
    bit ok;
    ok = (flt == e.fault) && (l == e.lvl) && (a == e.va);
    if (!e.fault) ok = ok && (p == e.ppn) && (pm == e.perm) && (nf == e.napot);
    chk(ok, e.req, flt ? "fault result" : "fill result",
        {flt, 3'b0, nf, l[3:0], p[43:0], pm[7:0]},
        {e.fault, 3'b0, e.napot, e.lvl[3:0], e.ppn[43:0], e.perm[7:0]});
  endtask

  // monitors (scoreboard)
  always @(negedge clk) if (rst_n) begin
    if (fv || fltv) begin
      if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected result", longint'(ova), 0);
      else cmp(exp_q.pop_front(), fltv, int'(olvl), longint'(fppn), int'(fperm),
               fnapot, longint'(ova));
    end
    if (mreq && addr_q.size() != 0) begin
      longint ea;
      ea = addr_q.pop_front();
      chk(longint'(maddr) == ea, "R2", "entry address", longint'(maddr), ea);
    end
    if (fv2 || fltv2) begin
      if (exp_q2.size() == 0) chk(1'b0, "R10", "unexpected result", longint'(ova2), 0);
      else cmp(exp_q2.pop_front(), fltv2, int'(olvl2), longint'(fppn2), int'(fperm2),
               fnapot2, longint'(ova2));
    end
  end

  task automatic walk(input bit second, input longint v, input exp_t e);
    e.va = v;
    if (second) exp_q2.push_back(e); else exp_q.push_back(e);
    @(negedge clk);
    if (second) begin
      req2 = 1'b1; va2 = v[38:0];
      @(negedge clk); req2 = 1'b0;
      wait (exp_q2.size() == 0);
    end else begin
      req = 1'b1; va = v[38:0];
      @(negedge clk); req = 1'b0;
      wait (exp_q.size() == 0);
    end
    @(negedge clk);
  endtask

  function automatic exp_t fl(input int l, input longint p, input int pm, input bit n,
                              input string r);
    exp_t e;
    e.fault = 1'b0; e.lvl = l; e.ppn = p; e.perm = pm; e.napot = n; e.va = 0; e.req = r;
    return e;
  endfunction

  function automatic exp_t ft(input int l, input string r);
    exp_t e;
    e.fault = 1'b1; e.lvl = l; e.ppn = 0; e.perm = 0; e.napot = 1'b0; e.va = 0; e.req = r;
    return e;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    req = 1'b0; req2 = 1'b0; va = '0; va2 = '0; root = 44'h100;
    mem[64'h100008] = mk(64'h200, 8'h01, 1'b0);
    mem[64'h100010] = mk(64'h80000, 8'hC7, 1'b1);
    mem[64'h200010] = mk(64'h300, 8'h01, 1'b0);
    mem[64'h200018] = mk(64'h40008, 8'hC7, 1'b1);
    mem[64'h200020] = mk(64'h40000, 8'hCB, 1'b0);
    mem[64'h300018] = mk(64'h12345, 8'hC7, 1'b0);
    mem[64'h300020] = mk(64'h55558, 8'hC7, 1'b1);
    mem[64'h300028] = mk(64'h55554, 8'hC7, 1'b1);
    mem[64'h300030] = mk(64'h11111, 8'h05, 1'b0);
    mem[64'h300038] = mk(64'h22222, 8'h01, 1'b0);
    repeat (3) @(negedge clk);
    // R1: idle outputs in reset and after release
    chk(!mreq && !fv && !fltv && !busy, "R1", "outputs in reset",
        {mreq, fv, fltv, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mreq && !fv && !fltv && !busy, "R1", "idle after reset",
        {mreq, fv, fltv, busy}, 0);

    // R2/R3/R5: three-level walk to a plain 4 KiB leaf
    addr_q.push_back(64'h100008); addr_q.push_back(64'h200010); addr_q.push_back(64'h300018);
    walk(1'b0, mkva(1, 2, 3), fl(2, 64'h12345, 8'hC7, 1'b0, "R5"));
    chk(addr_q.size() == 0, "R2", "reads issued", addr_q.size(), 0);
    // R6: legal 64 KiB marker
    walk(1'b0, mkva(1, 2, 4), fl(2, 64'h55558, 8'hC7, 1'b1, "R6"));
    // R7: reserved low pattern
    walk(1'b0, mkva(1, 2, 5), ft(2, "R7"));
    // R8: marker on megapage and gigapage
    walk(1'b0, mkva(1, 3, 0), ft(1, "R8"));
    walk(1'b0, mkva(2, 0, 0), ft(0, "R8"));
    // R4: invalid entry and write-without-read
    walk(1'b0, mkva(3, 0, 0), ft(0, "R4"));
    walk(1'b0, mkva(1, 2, 6), ft(2, "R4"));
    // R3: pointer at last level
    walk(1'b0, mkva(1, 2, 7), ft(2, "R3"));
    // R5: megapage leaf without marker
    walk(1'b0, mkva(1, 4, 9), fl(1, 64'h40000, 8'hCB, 1'b0, "R5"));

    // R11: request while busy is ignored
    exp_q.push_back(fl(2, 64'h12345, 8'hC7, 1'b0, "R11"));
    exp_q[0].va = mkva(1, 2, 3);
    @(negedge clk); req = 1'b1; va = mkva(1, 2, 3);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk(busy, "R11", "busy during walk", busy, 1);
    req = 1'b1; va = mkva(1, 2, 5);
    @(negedge clk); req = 1'b0;
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    chk(!busy, "R11", "idle after single result", busy, 0);

    // R10: build without NAPOT ignores the marker
    walk(1'b1, mkva(1, 2, 4), fl(2, 64'h55558, 8'hC7, 1'b0, "R10"));
    walk(1'b1, mkva(1, 2, 5), fl(2, 64'h55554, 8'hC7, 1'b0, "R10"));
    walk(1'b1, mkva(1, 3, 0), fl(1, 64'h40008, 8'hC7, 1'b0, "R10"));
    walk(1'b1, mkva(1, 2, 6), ft(2, "R10"));

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule